// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Guard

This block keeps the status byte of a serial flash device and rules on every modifying request. A command decoder in front of it presents one decoded strobe per cycle: latch-enable, latch-disable, status write with a data byte, page program with an address, sector erase with an address, or whole-array erase. In the same cycle the block raises exactly one of a grant or a deny flag for each modifying request. A grant pulses `op_start_o`, which starts an external array timer. The timer later answers with `done_i`. The status byte is always readable on `status_o`.

Three conditions decide whether a request is granted. The first is the write-enable latch. The second is a protected range of 64 KiB sectors, sized by a three-bit protection level and anchored at either the high or the low end of the 2 MiB array. The third is a hardware lock, which holds while the stored lock bit is set and the write-protect pin is low. The non-volatile bits are kept in registers that load from parameter defaults on reset.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset, `status_o` equals {DEF_SRWD, 0, DEF_TB, DEF_BP, 0, 0}. With the default parameters this is 0x00.
- R2: When not busy, `wren_i` sets the latch bit (status bit 1) on the next cycle and `wrdi_i` clears it.
- R3: While the latch bit is 0, every modifying request is denied and the status byte is left unchanged.
- R4: A granted request sets the busy bit (status bit 0) on the next cycle. Busy stays at 1 until `done_i`, and the cycle after `done_i` shows busy and latch both at 0. A `done_i` while idle has no effect.
- R5: While busy, every modifying request is denied, and `wren_i` and `wrdi_i` have no effect.
- R6: A granted status write stores data bit 7 in status bit 7 (lock), data bit 5 in status bit 5 (anchor), and data bits 4:2 in status bits 4:2 (level). Data bits 6, 1 and 0 are ignored, and status bit 6 always reads 0.
- R7: When status bit 7 is 1 and `wp_ni` is 0, a status write is denied. With `wp_ni` at 1 it follows the other rules.
- R8: A level N from 1 to 7 protects min(2^(N-1), 32) sectors. The sector index is address bits 20:16. With anchor 0 the protected sectors are the highest-numbered ones; with anchor 1 they are the lowest-numbered ones. A program or sector erase whose sector is protected is denied.
- R9: A whole-array erase is granted only when the level bits are all 0.
- R10: `grant_o` and `deny_o` use bit 0 for status write, bit 1 for program, bit 2 for sector erase and bit 3 for whole-array erase. They respond combinationally in the cycle of the strobe. For each strobed request exactly one of the two bits is 1, and both are 0 with no strobe. `op_start_o` equals the OR of `grant_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wren_i | input | 1 | Set write-enable latch strobe |
| wrdi_i | input | 1 | Clear write-enable latch strobe |
| wrsr_i | input | 1 | Status write strobe |
| wrsr_data_i | input | 8 | Status write data byte |
| pp_i | input | 1 | Page program strobe |
| pp_addr_i | input | ADDR_W | Page program byte address |
| se_i | input | 1 | Sector erase strobe |
| se_addr_i | input | ADDR_W | Sector erase byte address |
| be_i | input | 1 | Whole-array erase strobe |
| wp_ni | input | 1 | Write-protect pin, active low |
| done_i | input | 1 | Array timer completion pulse |
| op_start_o | output | 1 | Start pulse to array timer |
| status_o | output | 8 | Status byte |
| grant_o | output | 4 | Per-request accept flags |
| deny_o | output | 4 | Per-request reject flags |

## Verification
The checks assume that at most one command strobe is active in any cycle. The decoder guarantees this, and the bench drives every command through a single task that raises one strobe at a time. The checks also assume that `done_i` is meaningful only while busy. The bench pulses `done_i` only to end a cycle it started, plus one deliberate pulse while idle, which the block must ignore. Addresses always lie inside the ADDR_W space. The stimulus sweeps every sector against every level and both anchors.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
  localparam int N_REQ    = 4;
  localparam int REQ_WRSR = 0;
  localparam int REQ_PP   = 1;
  localparam int REQ_SE   = 2;
  localparam int REQ_BE   = 3;
  localparam int BP_W     = 3;
  localparam int N_ACHK   = 2;

  typedef struct packed {
    logic            srwd;
    logic            tb;
    logic [BP_W-1:0] bp;
  } nv_t;
endpackage

// File: rtl/fsr_area_check.sv
module fsr_area_check
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int SECTOR_W = 16
) (
  input  logic [BP_W-1:0]   bp_i,
  input  logic              tb_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int IDX_W    = ADDR_W - SECTOR_W;
  localparam int NUM_SECT = 1 << IDX_W;
  localparam logic [IDX_W:0] NUM_SECT_V = (IDX_W+1)'(NUM_SECT);

  logic [IDX_W:0] span;
  logic [IDX_W:0] idx;
  logic [31:0]    shamt;
  logic           unused_lo;

  assign unused_lo = ^addr_i[SECTOR_W-1:0];
  assign idx       = {1'b0, addr_i[ADDR_W-1:SECTOR_W]};
  assign shamt     = 32'(bp_i) - 32'd1;

  // sectors covered: 2^(level-1), capped at the whole array
  always_comb begin
    span = '0;
    if (bp_i != '0) begin
      if (shamt >= 32'(IDX_W)) span = NUM_SECT_V;
      else                     span = (IDX_W+1)'(1) << shamt;
    end
  end

  always_comb begin
    if (bp_i == '0) hit_o = 1'b0;
    else if (tb_i)  hit_o = (idx < span);
    else            hit_o = (idx >= (NUM_SECT_V - span));
  end
endmodule

// File: rtl/fsr_status_regs.sv
module fsr_status_regs
  import flash_sr_pkg::*;
#(
  parameter logic [BP_W-1:0] DEF_BP   = '0,
  parameter logic            DEF_TB   = 1'b0,
  parameter logic            DEF_SRWD = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_wel_i,
  input  logic clr_wel_i,
  input  logic start_i,
  input  logic done_i,
  input  logic nv_we_i,
  input  nv_t  nv_d_i,
  output logic wip_o,
  output logic wel_o,
  output nv_t  nv_o
);
  logic finish;
  assign finish = wip_o & done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wip_o <= 1'b0;
    end else if (start_i) begin
      wip_o <= 1'b1;
    end else if (finish) begin
      wip_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o <= 1'b0;
    end else if (finish || clr_wel_i) begin
      wel_o <= 1'b0;
    end else if (set_wel_i) begin
      wel_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_o.srwd <= DEF_SRWD;
      nv_o.tb   <= DEF_TB;
      nv_o.bp   <= DEF_BP;
    end else if (nv_we_i) begin
      nv_o <= nv_d_i;
    end
  end
endmodule

// File: rtl/fsr_cmd_gate.sv
module fsr_cmd_gate
  import flash_sr_pkg::*;
(
  input  logic             wren_i,
  input  logic             wrdi_i,
  input  logic [N_REQ-1:0] req_i,
  input  logic             wip_i,
  input  logic             wel_i,
  input  nv_t              nv_i,
  input  logic             wp_ni,
  input  logic [N_ACHK-1:0] hit_i,
  output logic [N_REQ-1:0] grant_o,
  output logic [N_REQ-1:0] deny_o,
  output logic             set_wel_o,
  output logic             clr_wel_o,
  output logic             nv_we_o
);
  logic             open;
  logic             hw_lock;
  logic [N_REQ-1:0] permit;

  assign open    = ~wip_i & wel_i;
  assign hw_lock = nv_i.srwd & ~wp_ni;

  for (genvar k = 0; k < N_REQ; k++) begin : g_req
    if (k == REQ_WRSR) begin : g_wrsr
      assign permit[k] = ~hw_lock;
    end else if (k == REQ_PP) begin : g_pp
      assign permit[k] = ~hit_i[0];
    end else if (k == REQ_SE) begin : g_se
      assign permit[k] = ~hit_i[1];
    end else begin : g_be
      assign permit[k] = (nv_i.bp == '0);
    end
    assign grant_o[k] = req_i[k] & open & permit[k];
    assign deny_o[k]  = req_i[k] & ~(open & permit[k]);
  end

  assign set_wel_o = wren_i & ~wip_i;
  assign clr_wel_o = wrdi_i & ~wip_i;
  assign nv_we_o   = grant_o[REQ_WRSR];
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import flash_sr_pkg::*;
#(
  parameter int              ADDR_W   = 21,
  parameter int              SECTOR_W = 16,
  parameter logic [BP_W-1:0] DEF_BP   = '0,
  parameter logic            DEF_TB   = 1'b0,
  parameter logic            DEF_SRWD = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              pp_i,
  input  logic [ADDR_W-1:0] pp_addr_i,
  input  logic              se_i,
  input  logic [ADDR_W-1:0] se_addr_i,
  input  logic              be_i,
  input  logic              wp_ni,
  input  logic              done_i,
  output logic              op_start_o,
  output logic [7:0]        status_o,
  output logic [N_REQ-1:0]  grant_o,
  output logic [N_REQ-1:0]  deny_o
);
  logic [N_REQ-1:0]  req;
  logic [N_ACHK-1:0] area_hit;
  logic [ADDR_W-1:0] chk_addr [N_ACHK];
  logic              wip, wel, set_wel, clr_wel, nv_we;
  nv_t               nv_q, nv_d;
  logic              unused_data;

  assign req[REQ_WRSR] = wrsr_i;
  assign req[REQ_PP]   = pp_i;
  assign req[REQ_SE]   = se_i;
  assign req[REQ_BE]   = be_i;

  assign chk_addr[0] = pp_addr_i;
  assign chk_addr[1] = se_addr_i;

  assign nv_d.srwd   = wrsr_data_i[7];
  assign nv_d.tb     = wrsr_data_i[5];
  assign nv_d.bp     = wrsr_data_i[4:2];
  assign unused_data = ^{wrsr_data_i[6], wrsr_data_i[1:0]};

  for (genvar g = 0; g < N_ACHK; g++) begin : g_achk
    fsr_area_check #(
      .ADDR_W  (ADDR_W),
      .SECTOR_W(SECTOR_W)
    ) u_area (
      .bp_i  (nv_q.bp),
      .tb_i  (nv_q.tb),
      .addr_i(chk_addr[g]),
      .hit_o (area_hit[g])
    );
  end

  fsr_cmd_gate u_gate (
    .wren_i   (wren_i),
    .wrdi_i   (wrdi_i),
    .req_i    (req),
    .wip_i    (wip),
    .wel_i    (wel),
    .nv_i     (nv_q),
    .wp_ni    (wp_ni),
    .hit_i    (area_hit),
    .grant_o  (grant_o),
    .deny_o   (deny_o),
    .set_wel_o(set_wel),
    .clr_wel_o(clr_wel),
    .nv_we_o  (nv_we)
  );

  fsr_status_regs #(
    .DEF_BP  (DEF_BP),
    .DEF_TB  (DEF_TB),
    .DEF_SRWD(DEF_SRWD)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_wel_i(set_wel),
    .clr_wel_i(clr_wel),
    .start_i  (op_start_o),
    .done_i   (done_i),
    .nv_we_i  (nv_we),
    .nv_d_i   (nv_d),
    .wip_o    (wip),
    .wel_o    (wel),
    .nv_o     (nv_q)
  );

  assign op_start_o = |grant_o;
  assign status_o   = {nv_q.srwd, 1'b0, nv_q.tb, nv_q.bp, wel, wip};
endmodule

// File: rtl/flash_sr_guard_chk.sv
module flash_sr_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wren_i,
  input logic       wrdi_i,
  input logic       wrsr_i,
  input logic       pp_i,
  input logic       se_i,
  input logic       be_i,
  input logic       wp_ni,
  input logic       done_i,
  input logic       op_start_o,
  input logic [7:0] status_o,
  input logic [3:0] grant_o,
  input logic [3:0] deny_o
);
  p_wel_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[0] && wren_i) |=> status_o[1]);
  p_wel_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[0] && wrdi_i) |=> !status_o[1]);
  p_no_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[1] |-> (grant_o == 4'b0));
  p_start_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |=> status_o[0]);
  p_busy_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !done_i) |=> status_o[0]);
  p_done_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && done_i) |=> (!status_o[0] && !status_o[1]));
  p_busy_deny_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |-> (grant_o == 4'b0));
  p_nv_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_o[0] |=> $stable(status_o[7:2]));
  p_bit6_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[6]);
  p_hw_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[7] && !wp_ni && wrsr_i) |-> deny_o[0]);
  p_bulk_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o[3] |-> (status_o[4:2] == 3'b0));
  p_split_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o | deny_o) == {be_i, se_i, pp_i, wrsr_i}) && ((grant_o & deny_o) == 4'b0));
  p_one_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wren_i, wrdi_i, wrsr_i, pp_i, se_i, be_i}));
endmodule

bind flash_sr_guard flash_sr_guard_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wren_i    (wren_i),
  .wrdi_i    (wrdi_i),
  .wrsr_i    (wrsr_i),
  .pp_i      (pp_i),
  .se_i      (se_i),
  .be_i      (be_i),
  .wp_ni     (wp_ni),
  .done_i    (done_i),
  .op_start_o(op_start_o),
  .status_o  (status_o),
  .grant_o   (grant_o),
  .deny_o    (deny_o)
);

// File: tb/tb_flash_sr_guard.sv
`timescale 1ns/1ps
module tb_flash_sr_guard;
  localparam int ADDR_W = 21;
  localparam int C_NONE = 0, C_WREN = 1, C_WRDI = 2, C_WRSR = 3, C_PP = 4, C_SE = 5, C_BE = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_ni, wren_i, wrdi_i, wrsr_i, pp_i, se_i, be_i, wp_ni, done_i;
  logic [7:0]        wrsr_data_i;
  logic [ADDR_W-1:0] pp_addr_i, se_addr_i;
  logic              op_start_o;
  logic [7:0]        status_o;
  logic [3:0]        grant_o, deny_o;

  flash_sr_guard dut (
    .clk_i(clk), .rst_ni(rst_ni), .wren_i(wren_i), .wrdi_i(wrdi_i),
    .wrsr_i(wrsr_i), .wrsr_data_i(wrsr_data_i), .pp_i(pp_i), .pp_addr_i(pp_addr_i),
    .se_i(se_i), .se_addr_i(se_addr_i), .be_i(be_i), .wp_ni(wp_ni), .done_i(done_i),
    .op_start_o(op_start_o), .status_o(status_o), .grant_o(grant_o), .deny_o(deny_o)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  bit wp_lvl = 1;
  int m_wip = 0, m_wel = 0, m_bp = 0, m_tb = 0, m_srwd = 0;

  function automatic bit m_prot(int a);
    int cnt, sec;
    if (m_bp == 0) return 0;
    cnt = 1;
    for (int i = 1; i < m_bp; i++) cnt = cnt * 2;
    if (cnt > 32) cnt = 32;
    sec = a / 65536;
    if (m_tb != 0) return sec < cnt;
    return sec >= 32 - cnt;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(int cmd, int d, int a, bit dn, string tag);
    bit       open, perm;
    int       idx;
    bit [3:0] eg, ed;
    int       es;
    @(negedge clk);
    wren_i = (cmd == C_WREN); wrdi_i = (cmd == C_WRDI); wrsr_i = (cmd == C_WRSR);
    pp_i = (cmd == C_PP); se_i = (cmd == C_SE); be_i = (cmd == C_BE);
    wrsr_data_i = d[7:0]; pp_addr_i = a[ADDR_W-1:0]; se_addr_i = a[ADDR_W-1:0];
    done_i = dn; wp_ni = wp_lvl;
    #1;
    open = (m_wip == 0) && (m_wel != 0);
    eg = '0; ed = '0; perm = 0; idx = 0;
    case (cmd)
      C_WRSR: begin idx = 0; perm = !(m_srwd != 0 && !wp_lvl); end
      C_PP:   begin idx = 1; perm = !m_prot(a); end
      C_SE:   begin idx = 2; perm = !m_prot(a); end
      C_BE:   begin idx = 3; perm = (m_bp == 0); end
      default: ;
    endcase
    if (cmd >= C_WRSR) begin
      if (open && perm) eg[idx] = 1'b1; else ed[idx] = 1'b1;
    end
    es = (m_srwd << 7) | (m_tb << 5) | (m_bp << 2) | (m_wel << 1) | m_wip;
    check(tag, "status", int'(status_o), es);
    check(tag, "grant", int'(grant_o), int'(eg));
    check(tag, "deny", int'(deny_o), int'(ed));
    check(tag, "start", int'(op_start_o), int'(eg != 0));
    if (m_wip != 0) begin
      if (dn) begin m_wip = 0; m_wel = 0; end
    end else begin
      if (cmd == C_WREN) m_wel = 1;
      if (cmd == C_WRDI) m_wel = 0;
      if (eg != 0) begin
        m_wip = 1;
        if (cmd == C_WRSR) begin
          m_srwd = (d >> 7) & 1; m_tb = (d >> 5) & 1; m_bp = (d >> 2) & 7;
        end
      end
    end
  endtask

  task automatic set_level(int lvl, int anchor, string tag);
    cyc(C_WREN, 0, 0, 0, tag);
    cyc(C_WRSR, (anchor << 5) | (lvl << 2), 0, 0, tag);
    cyc(C_NONE, 0, 0, 1, tag);
  endtask

  initial begin
    rst_ni = 0; wren_i = 0; wrdi_i = 0; wrsr_i = 0; pp_i = 0; se_i = 0; be_i = 0;
    wrsr_data_i = 0; pp_addr_i = 0; se_addr_i = 0; wp_ni = 1; done_i = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "reset status", int'(status_o), 0);
    check("R10", "reset grant", int'(grant_o | deny_o), 0);
    @(negedge clk);
    rst_ni = 1;
    cyc(C_NONE, 0, 0, 0, "R1");

    cyc(C_WRSR, 8'h9C, 0, 0, "R3");
    cyc(C_PP, 0, 0, 0, "R3");
    cyc(C_SE, 0, 21'h1F0000, 0, "R3");
    cyc(C_BE, 0, 0, 0, "R3");
    cyc(C_NONE, 0, 0, 0, "R3");

    cyc(C_WREN, 0, 0, 0, "R2");
    cyc(C_NONE, 0, 0, 0, "R2");
    cyc(C_WRDI, 0, 0, 0, "R2");
    cyc(C_NONE, 0, 0, 0, "R2");
    cyc(C_WREN, 0, 0, 0, "R2");

    cyc(C_WRSR, 8'hFF, 0, 0, "R6");
    cyc(C_WREN, 0, 0, 0, "R5");
    cyc(C_PP, 0, 0, 0, "R5");
    cyc(C_WRDI, 0, 0, 0, "R5");
    cyc(C_BE, 0, 0, 0, "R5");
    cyc(C_NONE, 0, 0, 1, "R4");
    cyc(C_NONE, 0, 0, 0, "R6");

    wp_lvl = 0;
    cyc(C_WREN, 0, 0, 0, "R7");
    cyc(C_WRSR, 8'h00, 0, 0, "R7");
    cyc(C_NONE, 0, 0, 0, "R7");
    wp_lvl = 1;
    cyc(C_WRSR, 8'h43, 0, 0, "R7");
    cyc(C_NONE, 0, 0, 1, "R7");
    cyc(C_NONE, 0, 0, 0, "R6");

    cyc(C_WREN, 0, 0, 0, "R9");
    cyc(C_BE, 0, 0, 0, "R9");
    cyc(C_NONE, 0, 0, 1, "R9");
    set_level(1, 0, "R9");
    cyc(C_WREN, 0, 0, 0, "R9");
    cyc(C_BE, 0, 0, 0, "R9");
    cyc(C_WRDI, 0, 0, 0, "R9");

    for (int lvl = 1; lvl < 8; lvl++) begin
      for (int anc = 0; anc < 2; anc++) begin
        set_level(lvl, anc, "R8");
        for (int sec = 0; sec < 32; sec++) begin
          cyc(C_WREN, 0, 0, 0, "R8");
          cyc((sec % 2 != 0) ? C_SE : C_PP, 0, sec * 65536 + sec * 123, 0, "R8");
          if (m_wip != 0) cyc(C_NONE, 0, 0, 1, "R8");
          else            cyc(C_WRDI, 0, 0, 0, "R8");
        end
      end
    end

    set_level(0, 0, "R4");
    cyc(C_WREN, 0, 0, 0, "R4");
    cyc(C_SE, 0, 21'h0A1234, 0, "R4");
    for (int i = 0; i < 5; i++) cyc(C_NONE, 0, 0, 0, "R4");
    cyc(C_NONE, 0, 0, 1, "R4");
    cyc(C_NONE, 0, 0, 1, "R4");
    cyc(C_NONE, 0, 0, 0, "R4");

    cyc(C_NONE, 8'hA5, 21'h1FFFFF, 0, "R10");
    cyc(C_NONE, 8'h5A, 21'h000001, 0, "R10");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule